// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single CPU-side requests into timed cycles on an external memory bus. A request carries the access direction, its width (byte or 16-bit word), an address and write data. With it comes a cycle configuration produced by an outside address decoder. The configuration selects a shared or separate address/data port, an 8-bit or 16-bit data path, and four timing knobs: a longer address-latch strobe, a gap before the read/write strobe, a count of wait states, and an idle recovery clock after reads. An external ready line can stretch any strobe for slow devices. A global enable turns all external accesses off when the system runs without external memory.

The sequencer accepts a request only while idle. It drives the latch strobe, the read and write strobes, a dedicated address port and a 16-bit data port with an output enable. It returns a one-clock acknowledge together with the read data. A word access on an 8-bit bus becomes two byte cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset ale_o, rd_o, wr_o, ad_oe_o and ack_o are 0 and ready_o is 1.
- R2: While ext_en_i is 0, a request starts no cycle: ale_o, rd_o, wr_o and ack_o stay 0 and ready_o stays 1.
- R3: A cycle opens with ale_o high for 1 clock, or 2 clocks when cfg_ale_ext_i was set. During that time addr_o carries the cycle address. With cfg_mux_i=1, ad_o carries the low 16 address bits with ad_oe_o=1. With cfg_mux_i=0 on a read, ad_oe_o is 0.
- R4: With cfg_rw_dly_i set, one clock with neither strobe active separates the fall of ale_o from the strobe. The clocks from acceptance to ack_o equal the sum of the phase lengths plus one.
- R5: rd_o or wr_o stays high for 1+cfg_waits_i clocks when rdy_i is high. rdy_i is not looked at while wait states remain.
- R6: After the wait states, each clock with rdy_i low extends the strobe by one clock.
- R7: Read data is taken from ad_i in the last strobe clock and shown on rdata_o while ack_o is high for one clock, directly after the final strobe. ad_oe_o is 0 whenever rd_o is 1. A byte read returns the low lane, with zero in bits 15:8.
- R8: During a write, ad_oe_o is 1 from the address phase through the strobe, except while the address is being sent on a shared port. The data lane is wdata[15:0] for a 16-bit word. Byte accesses and 8-bit buses place data on bits 7:0, with zero in bits 15:8.
- R9: A word access with cfg_bus8_i=1 runs two complete cycles. The first uses the request address and the low byte; the second uses address+1 and the high byte. The read result is {second byte, first byte}.
- R10: With cfg_tri_gap_i set, every read cycle is followed by one clock with ready_o low and no ale_o, including the clock in which ack_o is high. Writes get no such clock.
- R11: A request raised while ready_o is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_en_i | input | 1 | 1 enables external accesses |
| cfg_mux_i | input | 1 | 1 = address and data share ad_o |
| cfg_bus8_i | input | 1 | 1 = 8-bit external data path |
| cfg_ale_ext_i | input | 1 | 1 = two-clock latch strobe |
| cfg_rw_dly_i | input | 1 | 1 = one clock between latch strobe and strobe |
| cfg_tri_gap_i | input | 1 | 1 = idle clock after each read |
| cfg_waits_i | input | WAIT_W | Wait states added to the strobe |
| req_i | input | 1 | Access request, taken when ready_o is 1 |
| req_we_i | input | 1 | 1 = write |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Idle and able to take a request |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read result, valid with ack_o |
| rdy_i | input | 1 | External ready, high = finish strobe |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| addr_o | output | ADDR_W | Dedicated address port |
| ad_o | output | 16 | Data or shared address/data out |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | 16 | Data or shared address/data in |

## Verification
The hardest situation to reach from the ports is the read data path of a split access. There, a read in 8-bit multiplexed mode with the recovery clock inserts an idle clock between the two byte halves. Each half samples a different address, and the address increment can carry into bit 8. The bench returns, on ad_i, data derived from addr_o, so every byte half is traceable to the address actually sent. A vector with low address byte FF covers the carry. Ready stretching and the masking of ready during wait states are reached by holding rdy_i low and raising it after a chosen count of strobe clocks.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_ALE_X, ST_DLY, ST_STRB, ST_TRI
  } phase_e;

  typedef struct packed {
    logic mux;
    logic bus8;
    logic ale_ext;
    logic rw_dly;
    logic tri_gap;
  } bus_cfg_t;
endpackage

// File: rtl/ebs_wait_cnt.sv
module ebs_wait_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebs_bus_drv.sv
module ebs_bus_drv
  import ebs_pkg::*;
(
  input  phase_e              phase_i,
  input  bus_cfg_t            cfg_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic                sub_i,
  input  logic [DATA_W-1:0]   addr_lo_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   ad_o,
  output logic                ad_oe_o
);
  logic addr_ph, data_ph;
  logic [BYTE_W-1:0] lane_lo, lane_hi;

  always_comb begin
    addr_ph = (phase_i == ST_ALE) || (phase_i == ST_ALE_X);
    data_ph = (phase_i == ST_DLY) || (phase_i == ST_STRB);
    if (cfg_i.bus8) begin
      lane_hi = '0;
      lane_lo = sub_i ? wdata_i[DATA_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];
    end else begin
      lane_hi = word_i ? wdata_i[DATA_W-1:BYTE_W] : '0;
      lane_lo = wdata_i[BYTE_W-1:0];
    end
    if (cfg_i.mux && addr_ph) begin
      ad_o    = addr_lo_i;
      ad_oe_o = 1'b1;
    end else begin
      ad_o    = {lane_hi, lane_lo};
      // separate port: write data may lead the strobe from the address phase
      ad_oe_o = we_i && (data_ph || addr_ph);
    end
  end
endmodule

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_en_i,
  input  bus_cfg_t           cfg_i,
  input  logic [WAIT_W-1:0]  waits_i,
  input  logic               req_i,
  input  logic               req_we_i,
  input  logic               req_word_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic               rdy_i,
  input  logic [DATA_W-1:0]  ad_i,
  output phase_e             phase_o,
  output bus_cfg_t           cfg_o,
  output logic               we_o,
  output logic               word_o,
  output logic               sub_o,
  output logic [ADDR_W-1:0]  cur_addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               ready_o,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ale_o,
  output logic               rd_o,
  output logic               wr_o
);
  phase_e state_q, state_d;
  bus_cfg_t cfg_q;
  logic [WAIT_W-1:0] waits_q;
  logic we_q, word_q, sub_q, pend_q, ack_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic accept, split, last, strb_end, enter_strb, cnt_zero;

  assign accept   = (state_q == ST_IDLE) && req_i && ext_en_i;
  assign split    = word_q && cfg_q.bus8;
  assign last     = !split || sub_q;
  assign strb_end = (state_q == ST_STRB) && cnt_zero && rdy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ALE;
      ST_ALE:   state_d = cfg_q.ale_ext ? ST_ALE_X : (cfg_q.rw_dly ? ST_DLY : ST_STRB);
      ST_ALE_X: state_d = cfg_q.rw_dly ? ST_DLY : ST_STRB;
      ST_DLY:   state_d = ST_STRB;
      ST_STRB:  if (strb_end)
                  state_d = (!we_q && cfg_q.tri_gap) ? ST_TRI : (last ? ST_IDLE : ST_ALE);
      ST_TRI:   state_d = pend_q ? ST_ALE : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign enter_strb = (state_d == ST_STRB) && (state_q != ST_STRB);

  ebs_wait_cnt #(.W(WAIT_W)) i_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (enter_strb),
    .val_i  (waits_q),
    .dec_i  (state_q == ST_STRB),
    .zero_o (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      waits_q <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      sub_q   <= 1'b0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= strb_end && last;
      if (accept) begin
        cfg_q   <= cfg_i;
        waits_q <= waits_i;
        we_q    <= req_we_i;
        word_q  <= req_word_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        sub_q   <= 1'b0;
        pend_q  <= 1'b0;
        rdata_q <= '0;
      end
      if (strb_end) begin
        sub_q  <= sub_q | !last;
        pend_q <= !last;
        if (!we_q) begin
          if (cfg_q.bus8) begin
            if (sub_q) rdata_q[DATA_W-1:BYTE_W] <= ad_i[BYTE_W-1:0];
            else       rdata_q[BYTE_W-1:0]      <= ad_i[BYTE_W-1:0];
          end else begin
            rdata_q <= word_q ? ad_i : {{(DATA_W-BYTE_W){1'b0}}, ad_i[BYTE_W-1:0]};
          end
        end
      end
    end
  end

  assign phase_o    = state_q;
  assign cfg_o      = cfg_q;
  assign we_o       = we_q;
  assign word_o     = word_q;
  assign sub_o      = sub_q;
  assign cur_addr_o = addr_q + ADDR_W'(sub_q);
  assign wdata_o    = wdata_q;
  assign ready_o    = (state_q == ST_IDLE);
  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;
  assign ale_o      = (state_q == ST_ALE) || (state_q == ST_ALE_X);
  assign rd_o       = (state_q == ST_STRB) && !we_q;
  assign wr_o       = (state_q == ST_STRB) && we_q;

  a_r3_short_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ale_o) && !cfg_q.ale_ext) |=> !ale_o);
  a_r4_rw_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ale_o) && cfg_q.rw_dly) |-> !(rd_o || wr_o));
  a_r5_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_STRB) && !cnt_zero) |=> (state_q == ST_STRB));
  a_r7_ack_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(rd_o || wr_o));
  a_r10_tri_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_o) && cfg_q.tri_gap) |-> (!ale_o && !ready_o));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_en_i,
  input  logic               cfg_mux_i,
  input  logic               cfg_bus8_i,
  input  logic               cfg_ale_ext_i,
  input  logic               cfg_rw_dly_i,
  input  logic               cfg_tri_gap_i,
  input  logic [WAIT_W-1:0]  cfg_waits_i,
  input  logic               req_i,
  input  logic               req_we_i,
  input  logic               req_word_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [15:0]        req_wdata_i,
  output logic               ready_o,
  output logic               ack_o,
  output logic [15:0]        rdata_o,
  input  logic               rdy_i,
  output logic               ale_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [15:0]        ad_o,
  output logic               ad_oe_o,
  input  logic [15:0]        ad_i
);
  bus_cfg_t cfg_in, cfg_cur;
  phase_e phase;
  logic we, word, sub;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wdata;

  assign cfg_in = '{mux: cfg_mux_i, bus8: cfg_bus8_i, ale_ext: cfg_ale_ext_i,
                    rw_dly: cfg_rw_dly_i, tri_gap: cfg_tri_gap_i};

  ebs_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_en_i    (ext_en_i),
    .cfg_i       (cfg_in),
    .waits_i     (cfg_waits_i),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_word_i  (req_word_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rdy_i       (rdy_i),
    .ad_i        (ad_i),
    .phase_o     (phase),
    .cfg_o       (cfg_cur),
    .we_o        (we),
    .word_o      (word),
    .sub_o       (sub),
    .cur_addr_o  (cur_addr),
    .wdata_o     (wdata),
    .ready_o     (ready_o),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .ale_o       (ale_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o)
  );

  ebs_bus_drv i_bus_drv (
    .phase_i   (phase),
    .cfg_i     (cfg_cur),
    .we_i      (we),
    .word_i    (word),
    .sub_i     (sub),
    .addr_lo_i (cur_addr[DATA_W-1:0]),
    .wdata_i   (wdata),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o)
  );

  assign addr_o = cur_addr;

  a_r7_read_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !ad_oe_o);
  a_r8_write_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ad_oe_o);
endmodule

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
module test_ext_bus_seq;
  typedef struct packed {
    logic mux; logic b8; logic ale_ext; logic rwd; logic tg;
    logic [3:0] waits; logic we; logic word;
    logic [23:0] addr; logic [15:0] wdata;
    logic [7:0] e_ale; logic [7:0] e_strb; logic [7:0] e_t;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd0, 1'b0,1'b1,24'h001234,16'h0000,8'd1,8'd1, 8'd3},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd3, 1'b1,1'b1,24'h002468,16'hBEEF,8'd1,8'd4, 8'd6},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,4'd2, 1'b0,1'b1,24'h0135AC,16'h0000,8'd2,8'd3, 8'd6},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd0, 1'b1,1'b1,24'h00F00D,16'hCAFE,8'd1,8'd1, 8'd4},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'd1, 1'b0,1'b1,24'h000410,16'h0000,8'd2,8'd4, 8'd8},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,4'd0, 1'b1,1'b1,24'h0120FF,16'h1357,8'd4,8'd2, 8'd9},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,24'h000077,16'h0000,8'd1,8'd1, 8'd3},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd15,1'b0,1'b0,24'h00ABCD,16'h0000,8'd1,8'd16,8'd18},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,4'd0, 1'b0,1'b1,24'h0002FF,16'h0000,8'd2,8'd2, 8'd7},
    '{0,0,0,0,0,4'd0,1'b1,1'b0,24'h000050,16'hA1B2,8'd1,8'd1,8'd3}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, ext_en_i = 1'b1;
  logic cfg_mux_i = 0, cfg_bus8_i = 0, cfg_ale_ext_i = 0, cfg_rw_dly_i = 0, cfg_tri_gap_i = 0;
  logic [3:0] cfg_waits_i = '0;
  logic req_i = 0, req_we_i = 0, req_word_i = 0, rdy_i = 1;
  logic [23:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic ready_o, ack_o, ale_o, rd_o, wr_o, ad_oe_o;
  logic [15:0] rdata_o, ad_o, ad_i;
  logic [23:0] addr_o;
  int n_chk = 0, n_err = 0;

  always #2.5 clk_i = ~clk_i;
  assign ad_i = {~addr_o[7:0], addr_o[7:0] ^ 8'h3C};

  ext_bus_seq i_ext_bus_seq (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_lane(vec_t v, int sub);
    if (v.b8) return {8'h00, (sub != 0) ? v.wdata[15:8] : v.wdata[7:0]};
    return v.word ? v.wdata : {8'h00, v.wdata[7:0]};
  endfunction

  function automatic logic [15:0] exp_rdata(vec_t v);
    logic [23:0] a1 = v.addr + 24'd1;
    logic [7:0] lo = v.addr[7:0] ^ 8'h3C;
    if (!v.word) return {8'h00, lo};
    if (v.b8) return {a1[7:0] ^ 8'h3C, lo};
    return {~v.addr[7:0], lo};
  endfunction

  task automatic run(input vec_t v, input int rdy_rel, input bit poke, input string stag);
    int t = 0, n_ale = 0, n_strb = 0, sub = -1, bad = 0;
    bit prev_ale = 0, done = 0, rdy_ack = 0;
    logic [15:0] rd_seen = '0;
    logic [23:0] a;
    @(negedge clk_i);
    cfg_mux_i = v.mux; cfg_bus8_i = v.b8; cfg_ale_ext_i = v.ale_ext;
    cfg_rw_dly_i = v.rwd; cfg_tri_gap_i = v.tg; cfg_waits_i = v.waits;
    req_we_i = v.we; req_word_i = v.word; req_addr_i = v.addr; req_wdata_i = v.wdata;
    rdy_i = (rdy_rel == 0); req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    while (!done && t < 200) begin
      t++;
      if (ale_o) begin
        n_ale++;
        if (!prev_ale) sub++;
        a = v.addr + 24'(sub);
        if (addr_o !== a) bad++;
        if (v.mux) begin
          if (!ad_oe_o || ad_o !== a[15:0]) bad++;
        end else if (!v.we && ad_oe_o) bad++;
      end
      if (rd_o) begin n_strb++; if (ad_oe_o) bad++; end
      if (wr_o) begin n_strb++; if (!ad_oe_o || ad_o !== exp_lane(v, sub)) bad++; end
      if ((rd_o || wr_o) && rdy_rel != 0 && n_strb == rdy_rel) rdy_i = 1'b1;
      if (poke && n_strb == 1 && (rd_o || wr_o)) begin req_addr_i = 24'hABCDEF; req_i = 1'b1; end
      else req_i = 1'b0;
      if (ack_o) begin done = 1; rd_seen = rdata_o; rdy_ack = ready_o; end
      prev_ale = ale_o;
      if (!done) @(negedge clk_i);
    end
    chk("R3 latch strobe clocks", n_ale, v.e_ale);
    chk({stag, " strobe clocks"}, n_strb, v.e_strb);
    chk("R4 clocks to ack", t, v.e_t);
    chk("R8 bus contents mismatches", bad, 0);
    chk("R9 cycle count", sub + 1, (v.word && v.b8) ? 2 : 1);
    chk("R10 ready at ack", rdy_ack, !(v.tg && !v.we));
    if (!v.we) chk("R7 read data", rd_seen, exp_rdata(v));
    rdy_i = 1'b1;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    vec_t d;
    int cnt;
    #1;
    @(negedge clk_i);
    // R1 during and after reset
    chk("R1 ale/rd/wr/oe/ack", {ale_o, rd_o, wr_o, ad_oe_o, ack_o}, 0);
    chk("R1 ready", ready_o, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 outputs after release", {ale_o, rd_o, wr_o, ad_oe_o, ack_o, ready_o}, 1);

    for (int i = 0; i < NV; i++) run(VECS[i], 0, 1'b0, "R5");

    // R6: ready low past the wait states stretches the strobe
    d = '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,1'b0,1'b1,24'h000300,16'h0,8'd1,8'd4,8'd6};
    run(d, 4, 1'b0, "R6");
    // R5: ready low only during wait states changes nothing
    d = '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,1'b0,1'b1,24'h000344,16'h0,8'd1,8'd4,8'd6};
    run(d, 2, 1'b0, "R5 ready masked");

    // R11: request during a busy cycle is dropped
    d = '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,1'b0,1'b1,24'h000600,16'h0,8'd1,8'd3,8'd5};
    run(d, 0, 1'b1, "R11 busy");
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      if (ale_o || rd_o || wr_o || ack_o || !ready_o) cnt++;
    end
    chk("R11 activity after ignored request", cnt, 0);

    // R2: externals disabled
    @(negedge clk_i);
    ext_en_i = 1'b0; req_addr_i = 24'h000123; req_i = 1'b1;
    @(negedge clk_i); req_i = 1'b0;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      if (ale_o || rd_o || wr_o || ack_o || !ready_o) cnt++;
      @(negedge clk_i);
    end
    chk("R2 activity while disabled", cnt, 0);
    ext_en_i = 1'b1;

    summary();
    $finish;
  end
endmodule